// File: doc/BRIEF.md
# Serial Interface Control-Word Sequencer

This block is the processor-side register front end of a programmable serial port. A processor reaches it over an 8-bit write bus and an 8-bit read bus, with an active-low chip select, active-low read and write strobes, and a select line that picks either the data path or the control/status path. All writes to the control path share one address. Each control write is given a meaning by the writes that came before it since the last reset. The first is the mode word. A synchronous mode then takes one or two sync characters. Every control write after that is a command.

The block holds the mode word, the sync characters and the command word. It drives the active-low request-to-send and terminal-ready outputs from command bits. It latches error and sync/break events that the serial engine reports as single-cycle pulses, and it assembles the status word that a status read returns. A command bit rewinds the sequence so that software can reprogram the mode. The shifter, baud timing and sync hunt are outside this block. They reach it only through its status inputs and the data write strobe.

Top module: `usart_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a clock edge that sees `dev_reset` high, the block enters its reset state. In that state `rts_n` and `dtr_n` are high, `setup_done` is 0, the mode, command and sync-character registers are 0, all latched flags are 0, and the next control write is taken as a mode word.
- R2: The first control write after a reset is stored in `mode_word`. Bits [1:0] give the clock factor: 00 synchronous, 01 x1, 10 x16, 11 x64.
- R3: When a mode word with bits [1:0] not equal to 00 is written, `setup_done` rises after that write and the next control write is a command.
- R4: When a mode word with bits [1:0] = 00 is written, the next control write goes to `sync_char1`. If mode bit 7 is 1, `setup_done` rises after that write. If mode bit 7 is 0, a second control write goes to `sync_char2` and `setup_done` rises after it. Later control writes leave both sync registers unchanged.
- R5: While `setup_done` is 1, each control write is stored in `cmd_word`. `rts_n` is the inverse of command bit 5 and `dtr_n` is the inverse of command bit 1. Commands may be written any number of times.
- R6: A command with bit 6 set is an internal reset. It clears `cmd_word` (so `rts_n` and `dtr_n` go high) and clears `setup_done`, and the next control write is a mode word. `mode_word` keeps its value until that next mode write.
- R7: A write with `cd` = 0 is a data write. It raises `tx_wr` for exactly one cycle after the strobe edge, with `tx_data` holding the written byte. It does not change the mode, sync or command registers.
- R8: An access counts only while `cs_n` is low. A strobe held low for several cycles is a single access, taken on its falling edge.
- R9: While `cs_n` and `rd_n` are both low, `rd_data` returns the status word when `cd` = 1 and `rx_char` when `cd` = 0. At all other times `rd_data` is 0.
- R10: Status word bits 0 to 7 are, in order: `txrdy`, `rxrdy`, `txe`, parity error, overrun error, framing error, sync/break detect, `dsr`.
- R11: A pulse on `par_err_evt`, `ovr_err_evt` or `frm_err_evt` sets its error flag. A command with bit 4 set clears all three flags. A pulse that arrives in the same cycle as the clear leaves its flag set.
- R12: A pulse on `syn_evt` sets the sync/break flag. The flag clears on the clock edge where a status read strobe (`cd` = 1) ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized to `clk` |
| dev_reset | input | 1 | Active-high synchronous device reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | Path select: 1 = control/status, 0 = data |
| wr_data | input | 8 | Processor write data |
| rd_data | output | 8 | Processor read data |
| rx_char | input | 8 | Received character from the serial engine |
| txrdy | input | 1 | Transmitter ready status |
| rxrdy | input | 1 | Receiver holds a character |
| txe | input | 1 | Transmitter empty status |
| dsr | input | 1 | Data-set-ready level |
| par_err_evt | input | 1 | Parity error pulse |
| ovr_err_evt | input | 1 | Overrun error pulse |
| frm_err_evt | input | 1 | Framing error pulse |
| syn_evt | input | 1 | Sync or break detect pulse |
| mode_word | output | 8 | Stored mode word |
| cmd_word | output | 8 | Stored command word |
| sync_char1 | output | 8 | First sync character |
| sync_char2 | output | 8 | Second sync character |
| setup_done | output | 1 | Mode setup complete; control writes are commands |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| tx_wr | output | 1 | One-cycle data-write pulse |
| tx_data | output | 8 | Byte of the last data write |

## Verification
A wrong sequence state makes the next control write land in the wrong register. This shows on `mode_word`, `sync_char1`/`sync_char2`, `cmd_word` or `setup_done` in the cycle right after that write. It also shows on `rts_n` and `dtr_n` when the write was meant to be a command. The bench therefore runs every path through the sequence: asynchronous mode, one sync character, two sync characters, internal reset and device reset. It then checks the register that should have taken the byte and the registers that should not. Flag faults show on the next status read. The bench reads the status word before and after each clear, and with a set pulse and a clear arriving in the same cycle, to check priority.

// File: rtl/usart_cs_pkg.sv
package usart_cs_pkg;
  localparam int W = 8;

  typedef enum logic [1:0] {
    ST_MODE  = 2'd0,
    ST_SYNC1 = 2'd1,
    ST_SYNC2 = 2'd2,
    ST_CMD   = 2'd3
  } seq_st_e;

  // mode word fields
  localparam int MODE_ONE_SYNC = 7;
  // command word fields
  localparam int CMD_DTR   = 1;
  localparam int CMD_ERRCL = 4;
  localparam int CMD_RTS   = 5;
  localparam int CMD_IRST  = 6;
  // number of latched error flags: parity, overrun, framing
  localparam int NERR = 3;
endpackage

// File: rtl/usart_cs_bus_if.sv
module usart_cs_bus_if
  import usart_cs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         cd,
  input  logic [W-1:0] wr_data,
  output logic         ctrl_wr,
  output logic         data_wr,
  output logic         stat_rd_done,
  output logic         rd_active,
  output logic         tx_wr,
  output logic [W-1:0] tx_data
);
  logic wr_acc, rd_acc;
  logic wr_acc_q, rd_acc_q, rd_cd_q;
  logic wr_edge;
  logic tx_wr_n;
  logic [W-1:0] tx_data_n;

  assign wr_acc       = !cs_n && !wr_n;
  assign rd_acc       = !cs_n && !rd_n;
  assign wr_edge      = wr_acc && !wr_acc_q;
  assign ctrl_wr      = wr_edge && cd;
  assign data_wr      = wr_edge && !cd;
  assign stat_rd_done = rd_acc_q && !rd_acc && rd_cd_q;
  assign rd_active    = rd_acc;

  always_comb begin
    tx_wr_n   = data_wr;
    tx_data_n = tx_data;
    if (data_wr) tx_data_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_acc_q <= 1'b0;
      rd_acc_q <= 1'b0;
      rd_cd_q  <= 1'b0;
      tx_wr    <= 1'b0;
      tx_data  <= '0;
    end else begin
      wr_acc_q <= wr_acc;
      rd_acc_q <= rd_acc;
      if (rd_acc) rd_cd_q <= cd;
      tx_wr    <= tx_wr_n;
      tx_data  <= tx_data_n;
    end
  end
endmodule

// File: rtl/usart_cs_seq.sv
module usart_cs_seq
  import usart_cs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dev_reset,
  input  logic         ctrl_wr,
  input  logic [W-1:0] wdata,
  output seq_st_e      state,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] sync1_q,
  output logic [W-1:0] sync2_q,
  output logic [W-1:0] cmd_q,
  output logic         err_clr
);
  seq_st_e      st_n;
  logic [W-1:0] mode_n, sync1_n, sync2_n, cmd_n;

  always_comb begin
    st_n    = state;
    mode_n  = mode_q;
    sync1_n = sync1_q;
    sync2_n = sync2_q;
    cmd_n   = cmd_q;
    err_clr = 1'b0;
    if (dev_reset) begin
      st_n    = ST_MODE;
      mode_n  = '0;
      sync1_n = '0;
      sync2_n = '0;
      cmd_n   = '0;
    end else if (ctrl_wr) begin
      unique case (state)
        ST_MODE: begin
          mode_n = wdata;
          st_n   = (wdata[1:0] == 2'b00) ? ST_SYNC1 : ST_CMD;
        end
        ST_SYNC1: begin
          sync1_n = wdata;
          st_n    = mode_q[MODE_ONE_SYNC] ? ST_CMD : ST_SYNC2;
        end
        ST_SYNC2: begin
          sync2_n = wdata;
          st_n    = ST_CMD;
        end
        ST_CMD: begin
          err_clr = wdata[CMD_ERRCL];
          if (wdata[CMD_IRST]) begin
            cmd_n = '0;
            st_n  = ST_MODE;
          end else begin
            cmd_n = wdata;
          end
        end
        default: st_n = ST_MODE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_MODE;
      mode_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      cmd_q   <= '0;
    end else begin
      state   <= st_n;
      mode_q  <= mode_n;
      sync1_q <= sync1_n;
      sync2_q <= sync2_n;
      cmd_q   <= cmd_n;
    end
  end
endmodule

// File: rtl/usart_cs_status.sv
module usart_cs_status
  import usart_cs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_reset,
  input  logic [NERR-1:0] err_evt,
  input  logic            syn_evt,
  input  logic            err_clr,
  input  logic            stat_rd_done,
  input  logic            txrdy,
  input  logic            rxrdy,
  input  logic            txe,
  input  logic            dsr,
  output logic [NERR-1:0] err_q,
  output logic            syn_q,
  output logic [W-1:0]    status_word
);
  logic [NERR-1:0] err_n;
  logic            syn_n;

  always_comb begin
    err_n = err_q;
    syn_n = syn_q;
    if (err_clr)      err_n = '0;
    if (stat_rd_done) syn_n = 1'b0;
    err_n = err_n | err_evt;
    syn_n = syn_n | syn_evt;
    if (dev_reset) begin
      err_n = '0;
      syn_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      syn_q <= 1'b0;
    end else begin
      err_q <= err_n;
      syn_q <= syn_n;
    end
  end

  assign status_word = {dsr, syn_q, err_q, txe, rxrdy, txrdy};
endmodule

// File: rtl/usart_ctrl_seq.sv
module usart_ctrl_seq
  import usart_cs_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dev_reset,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         cd,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] rx_char,
  input  logic         txrdy,
  input  logic         rxrdy,
  input  logic         txe,
  input  logic         dsr,
  input  logic         par_err_evt,
  input  logic         ovr_err_evt,
  input  logic         frm_err_evt,
  input  logic         syn_evt,
  output logic [W-1:0] mode_word,
  output logic [W-1:0] cmd_word,
  output logic [W-1:0] sync_char1,
  output logic [W-1:0] sync_char2,
  output logic         setup_done,
  output logic         rts_n,
  output logic         dtr_n,
  output logic         tx_wr,
  output logic [W-1:0] tx_data
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  logic                  ctrl_wr, data_wr, stat_rd_done, rd_active, err_clr;
  logic [NERR-1:0]       err_evt, err_q;
  logic                  syn_q;
  logic [W-1:0]          status_word;
  seq_st_e               state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  assign err_evt = {frm_err_evt, ovr_err_evt, par_err_evt};

  usart_cs_bus_if u_bus (
    .clk(clk), .rst_n(rst_sync_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd(cd), .wr_data(wr_data), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
    .stat_rd_done(stat_rd_done), .rd_active(rd_active),
    .tx_wr(tx_wr), .tx_data(tx_data)
  );

  usart_cs_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .dev_reset(dev_reset), .ctrl_wr(ctrl_wr),
    .wdata(wr_data), .state(state), .mode_q(mode_word), .sync1_q(sync_char1),
    .sync2_q(sync_char2), .cmd_q(cmd_word), .err_clr(err_clr)
  );

  usart_cs_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .dev_reset(dev_reset), .err_evt(err_evt),
    .syn_evt(syn_evt), .err_clr(err_clr), .stat_rd_done(stat_rd_done),
    .txrdy(txrdy), .rxrdy(rxrdy), .txe(txe), .dsr(dsr),
    .err_q(err_q), .syn_q(syn_q), .status_word(status_word)
  );

  assign setup_done = (state == ST_CMD);
  assign rts_n      = !cmd_word[CMD_RTS];
  assign dtr_n      = !cmd_word[CMD_DTR];
  assign rd_data    = !rd_active ? '0 : (cd ? status_word : rx_char);
endmodule

// File: rtl/usart_ctrl_seq_chk.sv
module usart_ctrl_seq_chk
  import usart_cs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            dev_reset,
  input logic            ctrl_wr,
  input logic            data_wr,
  input logic [W-1:0]    wdata,
  input seq_st_e         state,
  input logic [W-1:0]    mode_q,
  input logic            setup_done,
  input logic            rts_n,
  input logic            dtr_n,
  input logic [NERR-1:0] err_q,
  input logic [NERR-1:0] err_evt,
  input logic            syn_q,
  input logic            syn_evt,
  input logic            stat_rd_done,
  input logic            tx_wr
);
  assert_dev_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> (rts_n && dtr_n && !setup_done && mode_q == '0 && err_q == '0));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && state == ST_MODE && !dev_reset) |=> (mode_q == $past(wdata)));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctrl_wr && state == ST_MODE) && !dev_reset) |=> $stable(mode_q));

  assert_async_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && state == ST_MODE && wdata[1:0] != 2'b00 && !dev_reset) |=> setup_done);

  assert_irst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && state == ST_CMD && wdata[CMD_IRST]) |=>
      (state == ST_MODE && rts_n && dtr_n));

  assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> $past(data_wr));

  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && state == ST_CMD && wdata[CMD_ERRCL] && err_evt == '0) |=> (err_q == '0));

  assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt[0] && !dev_reset) |=> err_q[0]);

  assert_syn_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_done && !syn_evt) |=> !syn_q);
endmodule

bind usart_ctrl_seq usart_ctrl_seq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .dev_reset(dev_reset), .ctrl_wr(ctrl_wr),
  .data_wr(data_wr), .wdata(wr_data), .state(state), .mode_q(mode_word),
  .setup_done(setup_done), .rts_n(rts_n), .dtr_n(dtr_n), .err_q(err_q),
  .err_evt(err_evt), .syn_q(syn_q), .syn_evt(syn_evt),
  .stat_rd_done(stat_rd_done), .tx_wr(tx_wr)
);

// File: tb/usart_ctrl_seq_bench.sv
`timescale 1ns/1ps
module usart_ctrl_seq_bench;
  logic clk = 1'b0;
  logic rst_n, dev_reset, cs_n, rd_n, wr_n, cd;
  logic [7:0] wr_data, rd_data, rx_char;
  logic txrdy, rxrdy, txe, dsr;
  logic par_err_evt, ovr_err_evt, frm_err_evt, syn_evt;
  logic [7:0] mode_word, cmd_word, sync_char1, sync_char2, tx_data;
  logic setup_done, rts_n, dtr_n, tx_wr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usart_ctrl_seq u_usart_ctrl_seq (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic sel, logic [7:0] v, int len = 1, logic csn = 1'b0);
    @(negedge clk);
    cs_n = csn; cd = sel; wr_data = v; wr_n = 1'b0;
    for (int i = 1; i < len; i++) @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic cpu_read(logic sel, output logic [7:0] v);
    @(negedge clk);
    cs_n = 1'b0; cd = sel; rd_n = 1'b0;
    #1 v = rd_data;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rts_n", {7'd0, rts_n}, 8'h01);
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
    chk("R1 setup_done", {7'd0, setup_done}, 8'h00);
    chk("R1 mode", mode_word, 8'h00);
    chk("R1 cmd", cmd_word, 8'h00);
    cpu_read(1'b1, v);
    chk("R10 status after reset", v, 8'h05);
  endtask

  task automatic t_async();
    cpu_write(1'b1, 8'h4E);
    chk("R2 mode load", mode_word, 8'h4E);
    chk("R3 setup after async mode", {7'd0, setup_done}, 8'h01);
    cpu_write(1'b1, 8'h22);
    chk("R5 cmd load", cmd_word, 8'h22);
    chk("R5 rts/dtr asserted", {6'd0, rts_n, dtr_n}, 8'h00);
    cpu_write(1'b1, 8'h02);
    chk("R5 second cmd", {6'd0, rts_n, dtr_n}, 8'h02);
  endtask

  task automatic t_irst();
    cpu_write(1'b1, 8'h40);
    chk("R6 setup cleared", {7'd0, setup_done}, 8'h00);
    chk("R6 rts/dtr inactive", {6'd0, rts_n, dtr_n}, 8'h03);
    chk("R6 cmd cleared", cmd_word, 8'h00);
    chk("R6 mode kept", mode_word, 8'h4E);
  endtask

  task automatic t_sync_two();
    cpu_write(1'b1, 8'h0C);
    chk("R2 sync mode load", mode_word, 8'h0C);
    chk("R4 not done after sync mode", {7'd0, setup_done}, 8'h00);
    cpu_write(1'b1, 8'h16, 3);
    chk("R4 sync1", sync_char1, 8'h16);
    chk("R8 long strobe is one write", {7'd0, setup_done}, 8'h00);
    cpu_write(1'b1, 8'h29);
    chk("R4 sync2", sync_char2, 8'h29);
    chk("R4 done after two syncs", {7'd0, setup_done}, 8'h01);
    cpu_write(1'b1, 8'h20);
    chk("R5 cmd after syncs", cmd_word, 8'h20);
    chk("R4 sync2 untouched by cmd", sync_char2, 8'h29);
  endtask

  task automatic t_sync_one();
    cpu_write(1'b1, 8'h40);
    cpu_write(1'b1, 8'h8C);
    cpu_write(1'b1, 8'h7E);
    chk("R4 single sync1", sync_char1, 8'h7E);
    chk("R4 done after one sync", {7'd0, setup_done}, 8'h01);
    cpu_write(1'b1, 8'h02);
    chk("R5 cmd after one sync", {6'd0, rts_n, dtr_n}, 8'h02);
    chk("R4 sync2 kept", sync_char2, 8'h29);
  endtask

  task automatic t_data();
    logic [7:0] v;
    cpu_write(1'b0, 8'hA5);
    chk("R7 tx_wr pulse", {7'd0, tx_wr}, 8'h01);
    chk("R7 tx_data", tx_data, 8'hA5);
    @(negedge clk);
    chk("R7 tx_wr one cycle", {7'd0, tx_wr}, 8'h00);
    chk("R7 cmd untouched", cmd_word, 8'h02);
    chk("R7 mode untouched", mode_word, 8'h8C);
    rx_char = 8'h3C;
    cpu_read(1'b0, v);
    chk("R9 data read", v, 8'h3C);
    chk("R9 idle rd_data", rd_data, 8'h00);
  endtask

  task automatic t_cs();
    cpu_write(1'b1, 8'hFF, 1, 1'b1);
    chk("R8 no write without cs", cmd_word, 8'h02);
  endtask

  task automatic pulse_evt(logic p, logic o, logic f, logic s);
    @(negedge clk);
    par_err_evt = p; ovr_err_evt = o; frm_err_evt = f; syn_evt = s;
    @(negedge clk);
    par_err_evt = 1'b0; ovr_err_evt = 1'b0; frm_err_evt = 1'b0; syn_evt = 1'b0;
  endtask

  task automatic t_flags();
    logic [7:0] v;
    pulse_evt(1'b1, 1'b1, 1'b1, 1'b1);
    cpu_read(1'b1, v);
    chk("R11 R10 all flags set", v, 8'h7D);
    cpu_read(1'b1, v);
    chk("R12 syndet cleared by read", v, 8'h3D);
    cpu_write(1'b1, 8'h10);
    cpu_read(1'b1, v);
    chk("R11 errors cleared", v, 8'h05);
    @(negedge clk);
    cs_n = 1'b0; cd = 1'b1; wr_data = 8'h10; wr_n = 1'b0; par_err_evt = 1'b1;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1; par_err_evt = 1'b0;
    cpu_read(1'b1, v);
    chk("R11 set wins over clear", v, 8'h0D);
    dsr = 1'b1;
    cpu_write(1'b1, 8'h10);
    cpu_read(1'b1, v);
    chk("R10 dsr bit", v, 8'h85);
    dsr = 1'b0;
  endtask

  task automatic t_devreset();
    cpu_write(1'b1, 8'h22);
    @(negedge clk);
    dev_reset = 1'b1;
    @(negedge clk);
    dev_reset = 1'b0;
    chk("R1 dev_reset rts/dtr", {6'd0, rts_n, dtr_n}, 8'h03);
    chk("R1 dev_reset setup", {7'd0, setup_done}, 8'h00);
    chk("R1 dev_reset mode", mode_word, 8'h00);
    chk("R1 dev_reset sync1", sync_char1, 8'h00);
    cpu_write(1'b1, 8'h4F);
    chk("R2 mode after dev_reset", mode_word, 8'h4F);
    chk("R3 setup after dev_reset", {7'd0, setup_done}, 8'h01);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dev_reset = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    cd = 1'b1; wr_data = 8'h00; rx_char = 8'h00;
    txrdy = 1'b1; rxrdy = 1'b0; txe = 1'b1; dsr = 1'b0;
    par_err_evt = 1'b0; ovr_err_evt = 1'b0; frm_err_evt = 1'b0; syn_evt = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_async();
    t_irst();
    t_sync_two();
    t_sync_one();
    t_data();
    t_cs();
    t_flags();
    t_devreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule